// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port Controller

This block owns the per-pin configuration of one small I/O port and turns it into pad controls. A simple register bus sets, for each pin, whether it serves as a plain I/O line or carries a peripheral signal. It also sets the pin's direction, its output level, its pull-up request, its pseudo open-drain mode, and two input-blocking modes (analog and special function). For every pin the block drives an output value, an output enable and a pull-up enable toward the pad. It returns a synchronized, gated copy of the pad level for internal use. The same value can be read back through the bus.

Two reset inputs are provided. The power-on reset clears all state. The deep-standby reset clears all state except the lowest function-select bits, which survive so that pins wired to always-on logic keep their routing. Build-time masks mark which pins have a pull-up resistor and which support pseudo open-drain. On the other pins the matching control bits are not stored and have no effect.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While power-on reset is asserted and in the first cycle after its release, every control register reads 0, `bus_rdata_o` is 0, `pad_oe_o` is 0, `pad_pu_o` is 0 and `din_o` is 0.
- R2: A write strobe stores `bus_wdata_i` at the word address `bus_addr_i`. The map is 0 function select, 1 direction, 2 output data, 3 pull-up, 4 pseudo open-drain, 5 analog enable, 6 special-function enable, 7 input data. `bus_rdata_o` shows, one cycle after an address is presented, the value that register held before that same clock edge.
- R3: A write to address 7 changes no state.
- R4: For a pin with function select 0, the driven level is its output-data bit and the drive enable is its direction bit (1 = output). With function select 1, the level is `periph_out_i` and the enable is `periph_oe_i`. `pad_out_o` always shows the driven level.
- R5: On a pin in `POD_MASK` (default 0x30) with pseudo open-drain set, `pad_oe_o` is 0 whenever the driven level is 1. A level of 0 is still driven. On pins outside the mask the bit reads back 0 and has no effect.
- R6: `pad_pu_o` equals pull-up bit AND `PU_MASK` (default 0xFE) AND NOT `pad_oe_o`. Pull-up bits outside the mask read back 0.
- R7: `din_o` is `pad_in_i` delayed by two clock edges. A bit is forced to 0 while that pin's analog-enable bit, special-function bit or `conv_oe_i` bit is 1.
- R8: Reading address 7 returns `din_o` as it was at the clock edge of the read.
- R9: Deep-standby reset clears every register except function-select bits below `KEEP_BITS` (default 5). Those bits keep their value and ignore writes while it is asserted. Power-on reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_rst_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| dstby_rst_n_i | input | 1 | Deep-standby reset, active low, asynchronous assert |
| bus_wr_i | input | 1 | One-cycle write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | N_PINS | Write data |
| bus_rdata_o | output | N_PINS | Registered read data |
| periph_out_i | input | N_PINS | Peripheral output level per pin |
| periph_oe_i | input | N_PINS | Peripheral output enable per pin |
| conv_oe_i | input | N_PINS | Converter output active per pin (blocks digital input) |
| pad_in_i | input | N_PINS | Asynchronous pad level |
| pad_out_o | output | N_PINS | Level to the pad driver |
| pad_oe_o | output | N_PINS | Pad driver enable |
| pad_pu_o | output | N_PINS | Pull-up enable |
| din_o | output | N_PINS | Synchronized, gated input value |

## Verification
The clocked properties assume that both reset inputs are released away from the clock edge, so release looks synchronous to the block. They also assume that bus, peripheral and converter inputs are steady around each rising edge. The stimulus respects both assumptions: every input, including reset assertion and release, is changed only on the falling edge. Reset pulses are injected at random between bus traffic, so the write and readback properties only count edges where reset was inactive in the previous sample.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_FSEL = 3'd0,
    REG_DIR  = 3'd1,
    REG_DOUT = 3'd2,
    REG_PULL = 3'd3,
    REG_ODRN = 3'd4,
    REG_ANA  = 3'd5,
    REG_SPEC = 3'd6,
    REG_DIN  = 3'd7
  } gpio_reg_e;

endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned       N         = 8,
  parameter int unsigned       KEEP_BITS = 5,
  parameter logic [N-1:0]      PU_MASK   = '1,
  parameter logic [N-1:0]      POD_MASK  = '0
) (
  input  logic                  clk_i,
  input  logic                  por_rst_n_i,
  input  logic                  dstby_rst_n_i,
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [N-1:0]          wdata_i,
  input  logic [N-1:0]          din_i,
  output logic [N-1:0]          fsel_o,
  output logic [N-1:0]          dir_o,
  output logic [N-1:0]          dout_o,
  output logic [N-1:0]          pull_o,
  output logic [N-1:0]          odrn_o,
  output logic [N-1:0]          ana_o,
  output logic [N-1:0]          spec_o,
  output logic [N-1:0]          rdata_o
);

  localparam logic [N-1:0] KEEP_MASK =
    (KEEP_BITS >= N) ? {N{1'b1}} : ~({N{1'b1}} << KEEP_BITS);

  logic rst_n;
  assign rst_n = por_rst_n_i & dstby_rst_n_i;

  logic [N-1:0] fsel_q, dir_q, dout_q, pull_q, odrn_q, ana_q, spec_q, rdata_q;
  logic [N-1:0] fsel_d, dir_d, dout_d, pull_d, odrn_d, ana_d, spec_d, rdata_d;
  logic         fsel_we, dir_we, dout_we, pull_we, odrn_we, ana_we, spec_we;

  // write decode; the input data address has no write enable at all
  always_comb begin
    fsel_we = wr_i && (gpio_reg_e'(addr_i) == REG_FSEL) && dstby_rst_n_i;
    dir_we  = wr_i && (gpio_reg_e'(addr_i) == REG_DIR);
    dout_we = wr_i && (gpio_reg_e'(addr_i) == REG_DOUT);
    pull_we = wr_i && (gpio_reg_e'(addr_i) == REG_PULL);
    odrn_we = wr_i && (gpio_reg_e'(addr_i) == REG_ODRN);
    ana_we  = wr_i && (gpio_reg_e'(addr_i) == REG_ANA);
    spec_we = wr_i && (gpio_reg_e'(addr_i) == REG_SPEC);
  end

  // next-state
  always_comb begin
    fsel_d = fsel_we ? wdata_i : fsel_q;
    dir_d  = dir_we  ? wdata_i : dir_q;
    dout_d = dout_we ? wdata_i : dout_q;
    pull_d = pull_we ? (wdata_i & PU_MASK) : pull_q;
    odrn_d = odrn_we ? (wdata_i & POD_MASK) : odrn_q;
    ana_d  = ana_we  ? wdata_i : ana_q;
    spec_d = spec_we ? wdata_i : spec_q;
    unique case (gpio_reg_e'(addr_i))
      REG_FSEL: rdata_d = fsel_q;
      REG_DIR:  rdata_d = dir_q;
      REG_DOUT: rdata_d = dout_q;
      REG_PULL: rdata_d = pull_q;
      REG_ODRN: rdata_d = odrn_q;
      REG_ANA:  rdata_d = ana_q;
      REG_SPEC: rdata_d = spec_q;
      REG_DIN:  rdata_d = din_i;
      default:  rdata_d = '0;
    endcase
  end

  // function select: low bits live in the always-on reset domain
  for (genvar i = 0; i < N; i++) begin : g_fsel
    logic bit_q;
    if (i < KEEP_BITS) begin : g_keep
      always_ff @(posedge clk_i or negedge por_rst_n_i) begin
        if (!por_rst_n_i) bit_q <= 1'b0;
        else              bit_q <= fsel_d[i];
      end
    end else begin : g_clear
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= fsel_d[i];
      end
    end
    assign fsel_q[i] = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dout_q  <= '0;
      pull_q  <= '0;
      odrn_q  <= '0;
      ana_q   <= '0;
      spec_q  <= '0;
      rdata_q <= '0;
    end else begin
      dir_q   <= dir_d;
      dout_q  <= dout_d;
      pull_q  <= pull_d;
      odrn_q  <= odrn_d;
      ana_q   <= ana_d;
      spec_q  <= spec_d;
      rdata_q <= rdata_d;
    end
  end

  assign fsel_o  = fsel_q;
  assign dir_o   = dir_q;
  assign dout_o  = dout_q;
  assign pull_o  = pull_q;
  assign odrn_o  = odrn_q;
  assign ana_o   = ana_q;
  assign spec_o  = spec_q;
  assign rdata_o = rdata_q;

  // R2: a write to the direction register is visible on the next cycle
  a_r2_dir_write_lands: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_i) && ($past(addr_i) == REG_DIR)) |-> (dir_o == $past(wdata_i)));

  // R2: readback of output data shows the value before the same-edge write
  a_r2_readback_dout: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(rst_n) && ($past(addr_i) == REG_DOUT)) |-> (rdata_o == $past(dout_o)));

  // R8: input data readback equals the gated input at the read edge
  a_r8_din_readback: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(rst_n) && ($past(addr_i) == REG_DIN)) |-> (rdata_o == $past(din_i)));

  // R9: kept function-select bits do not move during deep-standby reset
  a_r9_keep_stable: assert property (@(posedge clk_i) disable iff (!por_rst_n_i)
    !dstby_rst_n_i |=> $stable(fsel_o & KEEP_MASK));

endmodule

// File: rtl/gpio_in_gate.sv
module gpio_in_gate #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [N-1:0] pad_in_i,
  input  logic [N-1:0] ana_i,
  input  logic [N-1:0] spec_i,
  input  logic [N-1:0] conv_oe_i,
  output logic [N-1:0] din_o
);

  logic [N-1:0] meta_q, sync_q;
  logic [N-1:0] meta_d, sync_d;
  logic [N-1:0] block;

  always_comb begin
    meta_d = pad_in_i;
    sync_d = meta_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign block = ana_i | spec_i | conv_oe_i;
  assign din_o = sync_q & ~block;

  // R7: a pin can only read 1 if the pad was 1 two edges earlier
  a_r7_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($past(rst_n_i) && $past(rst_n_i, 2)) |-> ((din_o & ~$past(pad_in_i, 2)) == '0));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int unsigned  N        = 8,
  parameter logic [N-1:0] PU_MASK  = '1,
  parameter logic [N-1:0] POD_MASK = '0
) (
  input  logic [N-1:0] fsel_i,
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] dout_i,
  input  logic [N-1:0] pull_i,
  input  logic [N-1:0] odrn_i,
  input  logic [N-1:0] periph_out_i,
  input  logic [N-1:0] periph_oe_i,
  output logic [N-1:0] pad_out_o,
  output logic [N-1:0] pad_oe_o,
  output logic [N-1:0] pad_pu_o
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic lvl, en, oe;

    always_comb begin
      lvl = fsel_i[i] ? periph_out_i[i] : dout_i[i];
      en  = fsel_i[i] ? periph_oe_i[i]  : dir_i[i];
    end

    if (POD_MASK[i]) begin : g_pod
      assign oe = en & ~(odrn_i[i] & lvl);
    end else begin : g_push
      assign oe = en;
    end

    if (PU_MASK[i]) begin : g_pu
      assign pad_pu_o[i] = pull_i[i] & ~oe;
    end else begin : g_nopu
      assign pad_pu_o[i] = 1'b0;
    end

    assign pad_out_o[i] = lvl;
    assign pad_oe_o[i]  = oe;
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned       N_PINS    = 8,
  parameter int unsigned       KEEP_BITS = 5,
  parameter logic [N_PINS-1:0] PU_MASK   = 8'hFE,
  parameter logic [N_PINS-1:0] POD_MASK  = 8'h30
) (
  input  logic                  clk_i,
  input  logic                  por_rst_n_i,
  input  logic                  dstby_rst_n_i,
  input  logic                  bus_wr_i,
  input  logic [REG_ADDR_W-1:0] bus_addr_i,
  input  logic [N_PINS-1:0]     bus_wdata_i,
  output logic [N_PINS-1:0]     bus_rdata_o,
  input  logic [N_PINS-1:0]     periph_out_i,
  input  logic [N_PINS-1:0]     periph_oe_i,
  input  logic [N_PINS-1:0]     conv_oe_i,
  input  logic [N_PINS-1:0]     pad_in_i,
  output logic [N_PINS-1:0]     pad_out_o,
  output logic [N_PINS-1:0]     pad_oe_o,
  output logic [N_PINS-1:0]     pad_pu_o,
  output logic [N_PINS-1:0]     din_o
);

  logic rst_n;
  assign rst_n = por_rst_n_i & dstby_rst_n_i;

  logic [N_PINS-1:0] fsel, dir, dout, pull, odrn, ana, spec, din;

  gpio_ctrl_regs #(
    .N(N_PINS), .KEEP_BITS(KEEP_BITS), .PU_MASK(PU_MASK), .POD_MASK(POD_MASK)
  ) u_regs (
    .clk_i        (clk_i),
    .por_rst_n_i  (por_rst_n_i),
    .dstby_rst_n_i(dstby_rst_n_i),
    .wr_i         (bus_wr_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .din_i        (din),
    .fsel_o       (fsel),
    .dir_o        (dir),
    .dout_o       (dout),
    .pull_o       (pull),
    .odrn_o       (odrn),
    .ana_o        (ana),
    .spec_o       (spec),
    .rdata_o      (bus_rdata_o)
  );

  gpio_in_gate #(.N(N_PINS)) u_in (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n),
    .pad_in_i (pad_in_i),
    .ana_i    (ana),
    .spec_i   (spec),
    .conv_oe_i(conv_oe_i),
    .din_o    (din)
  );

  gpio_pad_drive #(.N(N_PINS), .PU_MASK(PU_MASK), .POD_MASK(POD_MASK)) u_drv (
    .fsel_i      (fsel),
    .dir_i       (dir),
    .dout_i      (dout),
    .pull_i      (pull),
    .odrn_i      (odrn),
    .periph_out_i(periph_out_i),
    .periph_oe_i (periph_oe_i),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .pad_pu_o    (pad_pu_o)
  );

  assign din_o = din;

  // R5: an open-drain pin never actively drives a high level
  a_r5_pod_no_high: assert property (@(posedge clk_i) disable iff (!rst_n)
    (odrn & pad_oe_o & pad_out_o) == '0);

  // R6: pull-up never fights an enabled driver
  a_r6_pu_off_driving: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pad_oe_o & pad_pu_o) == '0);

  // R4: peripheral-routed pins carry the peripheral level
  a_r4_periph_level: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fsel & (pad_out_o ^ periph_out_i)) == '0);

  // R1: control state is clear in the cycle after power-on reset release
  a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(por_rst_n_i) |-> ((fsel | dir | pull | ana | spec | bus_rdata_o) == '0));

endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

  localparam int N = 8;
  localparam logic [7:0] PU_M   = 8'hFE;
  localparam logic [7:0] POD_M  = 8'h30;
  localparam logic [7:0] KEEP_M = 8'h1F;

  logic       clk = 1'b0;
  logic       por_n, dstby_n, bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] wdata, rdata, p_out, p_oe, conv_oe, pad_in;
  logic [7:0] pad_out, pad_oe, pad_pu, din;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk_i(clk), .por_rst_n_i(por_n), .dstby_rst_n_i(dstby_n),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .periph_out_i(p_out), .periph_oe_i(p_oe),
    .conv_oe_i(conv_oe), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_pu_o(pad_pu), .din_o(din)
  );

  // behavioural reference state
  logic [7:0] m_reg [0:6];
  logic [7:0] m_hist [$];
  logic [7:0] m_rd = 8'h00;

  function automatic logic [7:0] m_sync();
    return (m_hist.size() >= 2) ? m_hist[0] : 8'h00;
  endfunction

  function automatic logic [7:0] m_din();
    return m_sync() & ~(m_reg[5] | m_reg[6] | conv_oe);
  endfunction

  function automatic logic [7:0] m_lvl();
    logic [7:0] r;
    for (int i = 0; i < N; i++) r[i] = m_reg[0][i] ? p_out[i] : m_reg[2][i];
    return r;
  endfunction

  function automatic logic [7:0] m_oe();
    logic [7:0] r;
    logic [7:0] l;
    l = m_lvl();
    for (int i = 0; i < N; i++) begin
      r[i] = m_reg[0][i] ? p_oe[i] : m_reg[1][i];
      if (POD_M[i] && m_reg[4][i] && l[i]) r[i] = 1'b0;
    end
    return r;
  endfunction

  always @(posedge clk or negedge por_n or negedge dstby_n) begin
    if (!por_n) begin
      for (int k = 0; k < 7; k++) m_reg[k] = 8'h00;
      m_hist = {};
      m_rd = 8'h00;
    end else if (!dstby_n) begin
      m_reg[0] = m_reg[0] & KEEP_M;
      for (int k = 1; k < 7; k++) m_reg[k] = 8'h00;
      m_hist = {};
      m_rd = 8'h00;
    end else begin
      m_rd = (bus_addr == 3'd7) ? m_din() : m_reg[bus_addr];
      if (bus_wr && bus_addr != 3'd7) begin
        case (bus_addr)
          3'd3:    m_reg[3] = wdata & PU_M;
          3'd4:    m_reg[4] = wdata & POD_M;
          default: m_reg[bus_addr] = wdata;
        endcase
      end
      m_hist.push_back(pad_in);
      if (m_hist.size() > 2) void'(m_hist.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 pad_out", pad_out, m_lvl());
    chk("R5 pad_oe", pad_oe, m_oe());
    chk("R6 pad_pu", pad_pu, m_reg[3] & PU_M & ~m_oe());
    chk("R7 din", din, m_din());
    chk("R2 rdata", rdata, m_rd);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    cyc();
    d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    por_n = 1'b0; dstby_n = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; wdata = 8'h00;
    p_out = 8'h00; p_oe = 8'h00; conv_oe = 8'h00; pad_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pad_oe, 8'h00);
    chk("R1 din in reset", din, 8'h00);
    por_n = 1'b1; dstby_n = 1'b1;
    cyc();
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    for (int a = 0; a < 7; a++) begin
      rreg(3'(a), v);
      chk("R1 reg clear", v, 8'h00);
    end

    // R4 plain output, then peripheral routing
    wreg(3'd1, 8'hFF);
    wreg(3'd2, 8'h5A);
    chk("R4 gpio level", pad_out, 8'h5A);
    chk("R4 gpio enable", pad_oe, 8'hFF);
    p_out = 8'hC3; p_oe = 8'h0F;
    wreg(3'd0, 8'hF0);
    chk("R4 periph level", pad_out, 8'hC3 & 8'hF0 | 8'h5A & 8'h0F);
    chk("R4 periph enable", pad_oe, 8'h0F & 8'hF0 | 8'h0F);
    wreg(3'd0, 8'h00);

    // R5 pseudo open-drain, R6 pull-up
    wreg(3'd2, 8'hFF);
    wreg(3'd4, 8'hFF);
    chk("R5 high released", pad_oe, 8'hCF);
    rreg(3'd4, v);
    chk("R5 readback masked", v, 8'h30);
    wreg(3'd2, 8'h00);
    chk("R5 low driven", pad_oe, 8'hFF);
    wreg(3'd2, 8'hFF);
    wreg(3'd3, 8'hFF);
    chk("R6 pull on released pins", pad_pu, 8'h30);
    wreg(3'd1, 8'h00);
    chk("R6 pull mask", pad_pu, 8'hFE);
    rreg(3'd3, v);
    chk("R6 readback masked", v, 8'hFE);

    // R7 synchronizer and gating, R8 readback, R3 read-only
    pad_in = 8'hA5;
    cyc();
    chk("R7 one edge", din, 8'h00);
    cyc();
    chk("R7 two edges", din, 8'hA5);
    wreg(3'd5, 8'h0F);
    chk("R7 analog gate", din, 8'hA0);
    wreg(3'd6, 8'h20);
    chk("R7 special gate", din, 8'h80);
    conv_oe = 8'h80;
    cyc();
    chk("R7 converter gate", din, 8'h00);
    conv_oe = 8'h00;
    wreg(3'd7, 8'hFF);
    rreg(3'd7, v);
    chk("R8 din readback", v, 8'h80);
    chk("R3 write ignored", din, 8'h80);
    wreg(3'd5, 8'h00);
    wreg(3'd6, 8'h00);
    rreg(3'd7, v);
    chk("R3 din after write", v, 8'hA5);

    // R9 deep-standby keeps low function-select bits
    wreg(3'd0, 8'hFF);
    dstby_n = 1'b0;
    bus_wr = 1'b1; bus_addr = 3'd0; wdata = 8'h00;
    cyc();
    bus_wr = 1'b0;
    dstby_n = 1'b1;
    rreg(3'd0, v);
    chk("R9 kept bits", v, 8'h1F);
    rreg(3'd2, v);
    chk("R9 others cleared", v, 8'h00);
    por_n = 1'b0;
    cyc();
    por_n = 1'b1;
    rreg(3'd0, v);
    chk("R9 por clears", v, 8'h00);

    // random traffic with occasional resets
    for (int n = 0; n < 4000; n++) begin
      cyc();
      bus_wr   = ($urandom % 2) == 0;
      bus_addr = 3'($urandom);
      wdata    = 8'($urandom);
      p_out    = 8'($urandom);
      p_oe     = 8'($urandom);
      conv_oe  = 8'($urandom & $urandom & $urandom);
      pad_in   = 8'($urandom);
      dstby_n  = ($urandom % 60) != 0;
      por_n    = ($urandom % 250) != 0;
    end
    por_n = 1'b1; dstby_n = 1'b1; bus_wr = 1'b0;
    repeat (3) cyc();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule